// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is the serial slave port of a measurement front end. A host reaches a bank of eight internal registers with widths of 8, 16 and 24 bits over a clock, a data-in line and a data-out line. A chip select is optional and may be tied low. Every access opens with an 8-bit command byte. That byte names the register and says whether to read or write it. The data phase that follows is as long as the addressed register. When a write completes, the port returns to waiting for a command. This lets a command and its data run as one unbroken burst, and it lets a host pad a short register with trailing ones.

The converter itself is not modelled. Its results arrive as a one-cycle strobe with a 24-bit word. A ready flag, visible both on a pin and in the status register, shows that an unread result is waiting. A continuous-read mode streams each result as a bare 24-bit frame with no command in front of it. The host leaves this mode only through the byte it shifts in at the start of a frame. All serial inputs are brought into the system clock domain, and the engine runs on the detected clock edges.

Top module: `sreg_spi_slave`

## Requirements
- R1: Command byte layout is {2'b00, cont(bit 5), read(bit 4), 1'b0, addr[2:0]}. The data phase length follows the address: 0 status 8 bits, 1 result 24, 2 mode 16, 3 filter 24, 4 dac 8, 5 offset 24, 6 gain 24, 7 aux 16.
- R2: Bits travel most significant first. The slave drives data-out on the leading edge (idle to active) and samples data-in on the trailing edge. pol_i=0 means the clock idles low; pol_i=1 means it idles high.
- R3: After a write's last bit, the port returns to command state. Command and data may form one continuous burst. Writes to addresses 0 and 1 consume their data phase and change nothing.
- R4: A command byte with bit 7, 6 or 3 set (0xFF included) is ignored, and the port stays in command state. Ones clocked in after a write therefore have no effect.
- R5: sdo_o is 0 except during a read data phase or a continuous-read frame.
- R6: A read returns the register value. Reset values are offset 0x800000, gain 0x400000 and 0 for all others.
- R7: While cs_ni is high, clock edges are ignored and the transfer state is held.
- R8: conv_valid_i stores conv_data_i in the result register and sets rdy_o. The status byte carries ready in bit 7 and continuous mode in bit 6.
- R9: Ready clears when a read of the result register completes. A result strobe that arrives while the result register is being read is dropped.
- R10: Command 0x31 enters continuous read. Each later 24-bit frame shifts out the result register without a command.
- R11: Continuous read ends only after a frame whose first 8 input bits equal 0x21. That frame finishes normally, and the port then returns to command state. Ones on data-in keep the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pol_i | input | 1 | Serial clock idle level select |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| conv_valid_i | input | 1 | Result strobe from converter |
| conv_data_i | input | DATA_W | Conversion result word |
| rdy_o | output | 1 | Unread result available |

## Verification
The hardest case to reach is a result strobe that lands in the middle of a read of the result register. It cannot be set up with whole transfers. The bench therefore splits one read into a command chunk, a 4-bit chunk and a 20-bit chunk, and pulses the strobe between them. It then checks the joined word, the ready pin and a second read. Continuous mode is driven with one frame of all ones, which must not exit, and then a frame that opens with the exit byte. A normal register read afterwards shows that command decoding has resumed.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int REG_W  = 24;
  localparam int ADDR_W = 3;
  localparam int NREG   = 1 << ADDR_W;

  typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD, ST_CONT} st_e;

  localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd1;
  localparam logic [ADDR_W-1:0] A_OFFS = 3'd5;
  localparam logic [ADDR_W-1:0] A_GAIN = 3'd6;

  localparam logic [7:0] CMD_EXIT = 8'h21;

  // register length in bytes
  function automatic logic [1:0] reg_bytes(input logic [ADDR_W-1:0] a);
    case (a)
      3'd0, 3'd4: reg_bytes = 2'd1;
      3'd2, 3'd7: reg_bytes = 2'd2;
      default:    reg_bytes = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int             N_SIG   = 3,
  parameter int             STAGES  = 2,
  parameter logic [N_SIG-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SIG-1:0] d_i,
  output logic [N_SIG-1:0] q_o
);
  logic [STAGES-1:0][N_SIG-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q <= RST_VAL;
        else         stg_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
  import sreg_pkg::*;
#(
  parameter int DW = REG_W,
  localparam int CW = $clog2(DW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_s_i,
  input  logic              cs_n_s_i,
  input  logic              sdi_s_i,
  input  logic [DW-1:0]     rd_val_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DW-1:0]     wr_data_o,
  output logic              sdo_o,
  output logic              data_busy_o,
  output logic              data_done_o,
  output logic              cont_o,
  output st_e               state_o,
  output logic [CW-1:0]     cnt_o,
  output logic [CW-1:0]     len_o
);
  st_e               state_q;
  logic              sck_d;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-2:0]     rx_q;
  logic [DW-1:0]     tx_q;
  logic              sdo_q, frame_q, exit_q;

  logic       lead, trail, cmd_ok, last;
  logic [7:0] cmd_byte;
  logic [CW-1:0] len_bits;

  assign lead     = !cs_n_s_i &&  sck_s_i && !sck_d;
  assign trail    = !cs_n_s_i && !sck_s_i &&  sck_d;
  assign cmd_byte = {rx_q[6:0], sdi_s_i};
  assign cmd_ok   = (cmd_byte[7:6] == 2'b00) && !cmd_byte[3];
  assign len_bits = CW'({reg_bytes(addr_q), 3'b000});
  assign last     = (cnt_q == CW'(len_bits - 1'b1));

  assign rd_addr_o = (state_q == ST_CMD) ? cmd_byte[2:0] : addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      sck_d   <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      sdo_q   <= 1'b0;
      frame_q <= 1'b0;
      exit_q  <= 1'b0;
    end else begin
      sck_d <= sck_s_i;
      if (!(state_q inside {ST_RD, ST_CONT})) sdo_q <= 1'b0;
      // keep the frame buffer tracking the result between frames
      if (state_q == ST_CONT && !frame_q && !lead) tx_q <= rd_val_i;
      if (lead && (state_q inside {ST_RD, ST_CONT})) begin
        sdo_q <= tx_q[DW-1];
        tx_q  <= {tx_q[DW-2:0], 1'b0};
        if (state_q == ST_CONT) frame_q <= 1'b1;
      end
      if (trail) begin
        rx_q <= {rx_q[DW-3:0], sdi_s_i};
        case (state_q)
          ST_CMD: begin
            if (cnt_q == CW'(7)) begin
              cnt_q <= '0;
              if (cmd_ok) begin
                addr_q <= cmd_byte[2:0];
                if (cmd_byte[5]) begin
                  if (cmd_byte[4] && cmd_byte[2:0] == A_DATA) begin
                    state_q <= ST_CONT;
                    frame_q <= 1'b0;
                    exit_q  <= 1'b0;
                  end
                end else if (cmd_byte[4]) begin
                  state_q <= ST_RD;
                  tx_q    <= rd_val_i << (DW - 8 * int'(reg_bytes(cmd_byte[2:0])));
                end else begin
                  state_q <= ST_WR;
                end
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_WR, ST_RD: begin
            if (last) begin
              state_q <= ST_CMD;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_CONT: begin
            if (cnt_q == CW'(7) && cmd_byte == CMD_EXIT) exit_q <= 1'b1;
            if (cnt_q == CW'(DW - 1)) begin
              cnt_q   <= '0;
              frame_q <= 1'b0;
              if (exit_q) state_q <= ST_CMD;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_CMD;
        endcase
      end
    end
  end

  assign wr_en_o     = trail && state_q == ST_WR && last;
  assign wr_addr_o   = addr_q;
  assign wr_data_o   = {rx_q, sdi_s_i};
  assign sdo_o       = sdo_q;
  assign data_busy_o = (state_q == ST_RD && addr_q == A_DATA) || (state_q == ST_CONT && frame_q);
  assign data_done_o = trail && ((state_q == ST_RD && last && addr_q == A_DATA) ||
                                 (state_q == ST_CONT && cnt_q == CW'(DW - 1)));
  assign cont_o      = state_q == ST_CONT;
  assign state_o     = state_q;
  assign cnt_o       = cnt_q;
  assign len_o       = len_bits;
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              conv_valid_i,
  input  logic [DW-1:0]     conv_data_i,
  input  logic              data_busy_i,
  input  logic              data_done_i,
  input  logic              cont_i,
  output logic [DW-1:0]     rd_val_o,
  output logic [DW-1:0]     data_o,
  output logic              rdy_o
);
  logic [NREG-1:0][DW-1:0] val;
  logic [DW-1:0]           data_q;
  logic                    rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
    end else if (conv_valid_i && !data_busy_i) begin
      data_q <= conv_data_i;
      rdy_q  <= 1'b1;
    end else if (data_done_i) begin
      rdy_q  <= 1'b0;
    end
  end

  generate
    for (genvar a = 0; a < NREG; a++) begin : g_reg
      if (a == int'(A_STAT)) begin : g_stat
        assign val[a] = {{(DW-8){1'b0}}, rdy_q, cont_i, 6'b0};
      end else if (a == int'(A_DATA)) begin : g_data
        assign val[a] = data_q;
      end else begin : g_rw
        localparam logic [ADDR_W-1:0] ADR = ADDR_W'(a);
        localparam logic [DW-1:0] MASK = {DW{1'b1}} >> (DW - 8 * int'(reg_bytes(ADR)));
        localparam logic [DW-1:0] RST  = (ADR == A_OFFS) ? DW'(1) << (DW - 1) :
                                         (ADR == A_GAIN) ? DW'(1) << (DW - 2) : '0;
        logic [DW-1:0] q;
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni)                           q <= RST;
          else if (wr_en_i && wr_addr_i == ADR)  q <= wr_data_i & MASK;
        assign val[a] = q;
      end
    end
  endgenerate

  assign rd_val_o = val[rd_addr_i];
  assign data_o   = data_q;
  assign rdy_o    = rdy_q;
endmodule

// File: rtl/sreg_spi_slave.sv
module sreg_spi_slave
  import sreg_pkg::*;
#(
  parameter int DATA_W      = REG_W,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pol_i,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic              conv_valid_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              rdy_o
);
  logic              cs_n_s, sck_s, sdi_s;
  logic [DATA_W-1:0] rd_val, wr_data, data_word;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              wr_en, data_busy, data_done, cont;
  st_e               ctl_state;
  logic [CW-1:0]     ctl_cnt, ctl_len;

  // polarity folded in before the synchronizer so a strap change makes no edge
  sreg_sync #(.N_SIG(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i ^ pol_i, sdi_i}),
    .q_o   ({cs_n_s, sck_s, sdi_s})
  );

  sreg_ctrl #(.DW(DATA_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_s_i    (sck_s),
    .cs_n_s_i   (cs_n_s),
    .sdi_s_i    (sdi_s),
    .rd_val_i   (rd_val),
    .rd_addr_o  (rd_addr),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .sdo_o      (sdo_o),
    .data_busy_o(data_busy),
    .data_done_o(data_done),
    .cont_o     (cont),
    .state_o    (ctl_state),
    .cnt_o      (ctl_cnt),
    .len_o      (ctl_len)
  );

  sreg_bank #(.DW(DATA_W)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .rd_addr_i   (rd_addr),
    .conv_valid_i(conv_valid_i),
    .conv_data_i (conv_data_i),
    .data_busy_i (data_busy),
    .data_done_i (data_done),
    .cont_i      (cont),
    .rd_val_o    (rd_val),
    .data_o      (data_word),
    .rdy_o       (rdy_o)
  );
endmodule

// File: rtl/sreg_spi_checker.sv
module sreg_spi_checker
  import sreg_pkg::*;
#(
  parameter int DW = REG_W,
  localparam int CW = $clog2(DW)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sdo_o,
  input logic          rdy_o,
  input logic          conv_valid_i,
  input logic          cs_n_s,
  input st_e           ctl_state,
  input logic [CW-1:0] ctl_cnt,
  input logic [CW-1:0] ctl_len,
  input logic          wr_en,
  input logic          data_busy,
  input logic [DW-1:0] data_word
);
  logic quiet_now;
  assign quiet_now = ctl_state inside {ST_CMD, ST_WR};

  assert_half_duplex_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet_now && $past(quiet_now) |-> !sdo_o);

  assert_cs_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s |=> $stable(ctl_cnt) && $stable(ctl_state));

  assert_data_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_busy |=> $stable(data_word));

  assert_rdy_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> $past(conv_valid_i));

  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_state inside {ST_WR, ST_RD}) |-> ctl_cnt < ctl_len);

  assert_wr_return_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> ctl_state == ST_CMD);
endmodule

bind sreg_spi_slave sreg_spi_checker #(.DW(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sdo_o       (sdo_o),
  .rdy_o       (rdy_o),
  .conv_valid_i(conv_valid_i),
  .cs_n_s      (cs_n_s),
  .ctl_state   (ctl_state),
  .ctl_cnt     (ctl_cnt),
  .ctl_len     (ctl_len),
  .wr_en       (wr_en),
  .data_busy   (data_busy),
  .data_word   (data_word)
);

// File: tb/sreg_spi_slave_bench.sv
module sreg_spi_slave_bench;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pol = 1'b0, cs_n = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic conv_valid = 1'b0;
  logic [23:0] conv_data = '0;
  logic sdo, rdy;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sreg_spi_slave u_sreg_spi_slave (
    .clk_i(clk), .rst_ni(rst_n), .pol_i(pol), .cs_ni(cs_n), .sclk_i(sclk),
    .sdi_i(sdi), .sdo_o(sdo), .conv_valid_i(conv_valid), .conv_data_i(conv_data),
    .rdy_o(rdy)
  );

  typedef struct packed {
    logic        pol;
    logic [5:0]  n;
    logic [39:0] mosi;
    logic [39:0] miso;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd32, 40'h02ABCDFF,   40'h0,        4'd3},  // R3 burst, R4 trailing no-op
    '{1'b0, 6'd24, 40'h120000,     40'h00ABCD,   4'd1},  // R1 16-bit read
    '{1'b1, 6'd16, 40'h045A,       40'h0,        4'd2},  // R2 idle-high write
    '{1'b1, 6'd16, 40'h1400,       40'h005A,     4'd2},  // R2 idle-high read
    '{1'b0, 6'd40, 40'h03123456FF, 40'h0,        4'd4},  // R4 ones after 24-bit write
    '{1'b1, 6'd32, 40'h13000000,   40'h00123456, 4'd1},  // R1 24-bit read
    '{1'b0, 6'd32, 40'h15000000,   40'h00800000, 4'd6},  // R6 offset reset
    '{1'b0, 6'd32, 40'h16000000,   40'h00400000, 4'd6},  // R6 gain reset
    '{1'b0, 6'd16, 40'h1000,       40'h0000,     4'd8},  // R8 status idle
    '{1'b0, 6'd32, 40'h01FFFFFF,   40'h0,        4'd5},  // R5 write phase output quiet
    '{1'b0, 6'd32, 40'h11000000,   40'h00000000, 4'd3},  // R3 read-only not written
    '{1'b0, 6'd32, 40'h82120000,   40'h0000ABCD, 4'd4},  // R4 reserved bit ignored
    '{1'b1, 6'd24, 40'h07BEEF,     40'h0,        4'd1},  // R1 aux write
    '{1'b1, 6'd24, 40'h170000,     40'h00BEEF,   4'd1}   // R1 aux read
  };

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input int n, input logic [39:0] din, output logic [39:0] dout);
    dout = '0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      sdi  = din[i];
      sclk = ~pol;
      repeat (HALF) @(negedge clk);
      dout[i] = sdo;
      sclk = pol;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic pulse_conv(input logic [23:0] v);
    @(negedge clk);
    conv_data  = v;
    conv_valid = 1'b1;
    @(negedge clk);
    conv_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_pol(input logic p);
    @(negedge clk);
    pol  = p;
    sclk = p;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [39:0] o1, o2, o3;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 rdy after reset", {39'b0, rdy}, 40'h0);
    chk("R5 sdo after reset", {39'b0, sdo}, 40'h0);

    for (int v = 0; v < NV; v++) begin
      set_pol(VECS[v].pol);
      shift_bits(int'(VECS[v].n), VECS[v].mosi, o1);
      checks++;
      if (o1 !== VECS[v].miso) begin
        fails++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h", VECS[v].req, v, o1, VECS[v].miso);
      end
    end

    set_pol(1'b0);
    // R8: capture and status
    pulse_conv(24'hC0FFEE);
    chk("R8 rdy set", {39'b0, rdy}, 40'h1);
    shift_bits(16, 40'h1000, o1);
    chk("R8 status ready bit", o1, 40'h0080);
    shift_bits(32, 40'h11000000, o1);
    chk("R8 result read", o1, 40'h00C0FFEE);
    repeat (4) @(negedge clk);
    chk("R9 rdy cleared after read", {39'b0, rdy}, 40'h0);

    // R9: strobe during a result read is dropped
    pulse_conv(24'h111111);
    shift_bits(8, 40'h11, o1);
    shift_bits(4, 40'h0, o2);
    pulse_conv(24'h222222);
    shift_bits(20, 40'h0, o3);
    chk("R9 read word unchanged", {16'b0, o2[3:0], o3[19:0]}, 40'h111111);
    repeat (4) @(negedge clk);
    chk("R9 rdy not set by dropped strobe", {39'b0, rdy}, 40'h0);
    shift_bits(32, 40'h11000000, o1);
    chk("R9 result kept", o1, 40'h00111111);

    // R7: edges with chip select high are ignored
    @(negedge clk) cs_n = 1'b1;
    repeat (4) @(negedge clk);
    shift_bits(16, 40'h04A5, o1);
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
    shift_bits(16, 40'h1400, o1);
    chk("R7 dac untouched", o1, 40'h005A);

    // R10 / R11: continuous read
    pulse_conv(24'h123ABC);
    shift_bits(8, 40'h31, o1);
    shift_bits(24, 40'hFFFFFF, o1);
    chk("R10 first frame", o1, 40'h123ABC);
    repeat (4) @(negedge clk);
    chk("R9 rdy cleared by frame", {39'b0, rdy}, 40'h0);
    pulse_conv(24'h456DEF);
    shift_bits(24, 40'h21FFFF, o1);
    chk("R11 ones kept mode, second frame", o1, 40'h456DEF);
    shift_bits(24, 40'h120000, o1);
    chk("R11 command state after exit", o1, 40'h00ABCD);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule